// File: doc/BRIEF.md
# Transaction Nesting and Abort Status Unit

This block keeps the transactional state of a single hardware thread. Decode logic hands it begin, end, explicit-abort and test requests. The memory system reports abort causes on separate wires: a conflict with another agent, an overflow of an internal tracking buffer, a debug breakpoint, and an abort with no recognised cause. Nesting is flattened. Every begin deepens a counter, but only the outermost begin records a fallback target. Only a return to depth zero produces a commit strobe toward the cache.

When an abort occurs, the unit raises an abort strobe, clears the depth and publishes a 32-bit status word. Software branches on that word at the recorded fallback target. The same result register returns all ones after a successful begin, so a single comparison tells the two outcomes apart. Requests are sampled on a rising edge, and every output is registered, so results appear one clock after the request. At most one of begin, end and explicit abort is presented per cycle.

Top module: `txn_nest_unit`

## Requirements
- R1: A begin taken at depth 0 latches `begin_target` into `fallback_o`. Inner begins leave `fallback_o` unchanged. Every accepted begin loads `status_o` with 32'hFFFF_FFFF.
- R2: Each end taken inside a transaction lowers the depth by one. `commit_o` pulses for one cycle only on the end that brings the depth from 1 to 0.
- R3: `test_val` is registered from a `test_req` and reads 1 when the depth is non-zero and 0 otherwise.
- R4: An explicit abort inside a transaction sets status bit 0, places `xabort_imm` in bits 31:24 and forces bit 1 to 0, even when a conflict arrives in the same cycle.
- R5: A conflict abort sets status bit 2 and bit 1 (retry may succeed).
- R6: An overflow input sets bit 3 and a breakpoint input sets bit 4. Bits 6 to 23 are zero in every abort status. Bits 31:24 are zero when bit 0 is clear.
- R7: Status bit 5 is set when the abort happens at a depth of 2 or more.
- R8: An abort through `abort_other_i` at depth 1 reports a status of exactly 32'h0000_0000.
- R9: A begin issued at depth MAX_NEST is not accepted. It aborts with bit 3 set, and bit 5 is also set when MAX_NEST is at least 2.
- R10: An end or explicit abort at depth 0 pulses `illegal_o` and leaves the depth at 0. Abort-cause inputs at depth 0 have no effect.
- R11: Any abort raises `abort_o` for one cycle and returns the depth to 0 in that same cycle. `fallback_o` keeps the outermost target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| begin_req | input | 1 | Begin a (possibly nested) transaction |
| begin_target | input | ADDR_W | Fallback target carried by the begin |
| end_req | input | 1 | End the innermost transaction level |
| xabort_req | input | 1 | Explicit abort request |
| xabort_imm | input | 8 | Immediate of the explicit abort |
| test_req | input | 1 | Query whether a transaction is active |
| conflict_i | input | 1 | Conflict reported by the memory system |
| overflow_i | input | 1 | Tracking buffer overflow reported |
| breakpoint_i | input | 1 | Debug breakpoint hit |
| abort_other_i | input | 1 | Abort with no recognised cause |
| status_o | output | 32 | All ones after a begin, abort status after an abort |
| fallback_o | output | ADDR_W | Fallback target of the outermost begin |
| test_val | output | 1 | Answer to the last test query |
| commit_o | output | 1 | Commit strobe toward the cache |
| abort_o | output | 1 | Abort strobe toward the cache |
| illegal_o | output | 1 | End or explicit abort outside a transaction |

## Verification
A wrong depth shows first through `test_val`, one cycle after the next query. It also shows through a commit that fires on the wrong end, or one that never fires. A depth that is not cleared on abort makes the following outer begin behave as an inner one, which leaves `fallback_o` stale. A mis-assembled status word is visible in the cycle right after the abort strobe. The bench therefore checks each abort status bit by bit in that cycle, and confirms the depth with a test query after every abort and every illegal operation.

// File: rtl/txn_nest_pkg.sv
// Shared bit positions of the abort status word and the success code.
package txn_nest_pkg;
    localparam int ST_EXPLICIT = 0;
    localparam int ST_RETRY    = 1;
    localparam int ST_CONFLICT = 2;
    localparam int ST_OVERFLOW = 3;
    localparam int ST_BREAK    = 4;
    localparam int ST_NESTED   = 5;
    localparam int ST_IMM_LO   = 24;
    localparam logic [31:0] BEGIN_OK = 32'hFFFF_FFFF;

    typedef struct packed {
        logic       explicit_ab;
        logic       conflict;
        logic       overflow;
        logic       breakpt;
        logic       nested;
        logic [7:0] imm;
    } abort_cause_t;
endpackage

// File: rtl/txn_depth_ctr.sv
// Nesting depth counter.
// Assumes inc and dec are never raised together; clr wins over both.
module txn_depth_ctr #(
    parameter int MAX_NEST = 4,
    localparam int DW = $clog2(MAX_NEST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          clr,
    output logic [DW-1:0] depth_o,
    output logic          at_max_o,
    output logic          nz_o,
    output logic          deep_o
);
    logic [DW-1:0] depth_q;

    // Update the depth: clear on abort, otherwise step up or down.
    always_ff @(posedge clk) begin
        if (!rst_n)   depth_q <= '0;
        else if (clr) depth_q <= '0;
        else if (inc) depth_q <= depth_q + 1'b1;
        else if (dec) depth_q <= depth_q - 1'b1;
    end

    assign depth_o  = depth_q;
    assign at_max_o = (depth_q == DW'(MAX_NEST));
    assign nz_o     = (depth_q != '0);
    assign deep_o   = (depth_q > DW'(1));

    // R9
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= DW'(MAX_NEST));
    // R2
    no_inc_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && dec));
endmodule

// File: rtl/txn_status_gen.sv
// Builds the 32-bit abort status word from the causes of one abort.
// Assumes the cause fields are already qualified by an active transaction.
module txn_status_gen
    import txn_nest_pkg::*;
(
    input  abort_cause_t cause,
    output logic [31:0]  status
);
    // Assemble the fields; retry is suppressed by an explicit abort.
    always_comb begin
        status                 = '0;
        status[ST_EXPLICIT]    = cause.explicit_ab;
        status[ST_RETRY]       = cause.conflict && !cause.explicit_ab;
        status[ST_CONFLICT]    = cause.conflict;
        status[ST_OVERFLOW]    = cause.overflow;
        status[ST_BREAK]       = cause.breakpt;
        status[ST_NESTED]      = cause.nested;
        status[ST_IMM_LO +: 8] = cause.explicit_ab ? cause.imm : 8'h00;
    end
endmodule

// File: rtl/txn_nest_unit.sv
// Transaction nesting and abort status unit for one hardware thread.
// Flattened nesting: only the outermost begin records the fallback target,
// only the end back to depth 0 commits. All outputs are registered.
// Assumes at most one of begin/end/xabort per cycle.
module txn_nest_unit
    import txn_nest_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MAX_NEST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              begin_req,
    input  logic [ADDR_W-1:0] begin_target,
    input  logic              end_req,
    input  logic              xabort_req,
    input  logic [7:0]        xabort_imm,
    input  logic              test_req,
    input  logic              conflict_i,
    input  logic              overflow_i,
    input  logic              breakpoint_i,
    input  logic              abort_other_i,
    output logic [31:0]       status_o,
    output logic [ADDR_W-1:0] fallback_o,
    output logic              test_val,
    output logic              commit_o,
    output logic              abort_o,
    output logic              illegal_o
);
    localparam int DW = $clog2(MAX_NEST + 1);

    logic [DW-1:0] depth;
    logic          at_max, in_txn, deep;
    logic          ext_abort, nest_ovf, do_abort;
    logic          do_inc, do_dec, do_commit, do_illegal;
    abort_cause_t  cause;
    logic [31:0]   ab_status;

    // Decide this cycle's action from requests and current depth.
    always_comb begin
        ext_abort  = in_txn && (conflict_i || overflow_i || breakpoint_i ||
                                abort_other_i || xabort_req);
        nest_ovf   = !ext_abort && begin_req && at_max;
        do_abort   = ext_abort || nest_ovf;
        do_inc     = !do_abort && begin_req;
        do_dec     = !do_abort && !begin_req && end_req && in_txn;
        do_commit  = do_dec && (depth == DW'(1));
        do_illegal = !begin_req && !in_txn && (end_req || xabort_req);
    end

    // Collect the causes that shape the status word.
    always_comb begin
        cause.explicit_ab = ext_abort && xabort_req;
        cause.conflict    = ext_abort && conflict_i;
        cause.overflow    = (ext_abort && overflow_i) || nest_ovf;
        cause.breakpt     = ext_abort && breakpoint_i;
        cause.nested      = deep;
        cause.imm         = xabort_imm;
    end

    txn_depth_ctr #(.MAX_NEST(MAX_NEST)) u_depth (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (do_inc),
        .dec      (do_dec),
        .clr      (do_abort),
        .depth_o  (depth),
        .at_max_o (at_max),
        .nz_o     (in_txn),
        .deep_o   (deep)
    );

    txn_status_gen u_status (
        .cause  (cause),
        .status (ab_status)
    );

    // Register strobes, the query answer and the result word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o  <= '0;
            test_val  <= 1'b0;
            commit_o  <= 1'b0;
            abort_o   <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            commit_o  <= do_commit;
            abort_o   <= do_abort;
            illegal_o <= do_illegal;
            test_val  <= test_req && in_txn;
            if (do_abort)    status_o <= ab_status;
            else if (do_inc) status_o <= BEGIN_OK;
        end
    end

    // Latch the fallback target on the outermost begin only.
    always_ff @(posedge clk) begin
        if (!rst_n)                  fallback_o <= '0;
        else if (do_inc && !in_txn)  fallback_o <= begin_target;
    end

    // R11
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (depth == '0));
    // R2
    commit_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (depth == '0) && !abort_o);
    // R4
    retry_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && status_o[ST_EXPLICIT]) |-> !status_o[ST_RETRY]);
    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (status_o[23:6] == '0));
    // R10
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (depth == '0) && !commit_o && !abort_o);
    // R1
    inner_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (begin_req && in_txn) |=> $stable(fallback_o));
endmodule

// File: tb/txn_nest_unit_tb.sv
module txn_nest_unit_tb;
    localparam int AW = 32;
    localparam int MN = 4;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          begin_req = 0, end_req = 0, xabort_req = 0, test_req = 0;
    logic [AW-1:0] begin_target = '0;
    logic [7:0]    xabort_imm = '0;
    logic          conflict_i = 0, overflow_i = 0, breakpoint_i = 0, abort_other_i = 0;
    logic [31:0]   status_o;
    logic [AW-1:0] fallback_o;
    logic          test_val, commit_o, abort_o, illegal_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    txn_nest_unit #(.ADDR_W(AW), .MAX_NEST(MN)) u_dut (
        .clk(clk), .rst_n(rst_n), .begin_req(begin_req), .begin_target(begin_target),
        .end_req(end_req), .xabort_req(xabort_req), .xabort_imm(xabort_imm),
        .test_req(test_req), .conflict_i(conflict_i), .overflow_i(overflow_i),
        .breakpoint_i(breakpoint_i), .abort_other_i(abort_other_i),
        .status_o(status_o), .fallback_o(fallback_o), .test_val(test_val),
        .commit_o(commit_o), .abort_o(abort_o), .illegal_o(illegal_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: inputs set at negedge, applied at posedge, released after.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        begin_req = 0; end_req = 0; xabort_req = 0; test_req = 0;
        conflict_i = 0; overflow_i = 0; breakpoint_i = 0; abort_other_i = 0;
    endtask

    task automatic do_begin(logic [AW-1:0] t);
        begin_req = 1; begin_target = t; tick();
    endtask
    task automatic do_end();   end_req = 1; tick(); endtask
    task automatic do_xab(logic [7:0] i); xabort_req = 1; xabort_imm = i; tick(); endtask
    task automatic query(string req, logic exp);
        test_req = 1; tick(); chk(req, {31'b0, test_val}, {31'b0, exp});
    endtask

    task automatic t_reset();
        chk("R3 reset status", status_o, 32'h0);
        chk("R2 reset commit", {31'b0, commit_o}, 32'h0);
        chk("R11 reset abort", {31'b0, abort_o}, 32'h0);
        query("R3 reset test", 1'b0);
    endtask

    task automatic t_nest_commit();
        do_begin(32'hA000_0010);
        chk("R1 outer begin status", status_o, 32'hFFFF_FFFF);
        chk("R1 outer target", fallback_o, 32'hA000_0010);
        query("R3 test in txn", 1'b1);
        do_begin(32'hB000_0020);
        chk("R1 inner begin status", status_o, 32'hFFFF_FFFF);
        chk("R1 inner target ignored", fallback_o, 32'hA000_0010);
        do_end();
        chk("R2 inner end no commit", {31'b0, commit_o}, 32'h0);
        query("R2 still in txn", 1'b1);
        do_end();
        chk("R2 outer end commits", {31'b0, commit_o}, 32'h1);
        tick();
        chk("R2 commit one cycle", {31'b0, commit_o}, 32'h0);
        query("R3 test after commit", 1'b0);
    endtask

    task automatic t_explicit();
        do_begin(32'h0000_1000);
        do_begin(32'h0000_2000);
        do_xab(8'h5A);
        chk("R4 R7 explicit nested status", status_o, 32'h5A00_0021);
        chk("R11 abort strobe", {31'b0, abort_o}, 32'h1);
        chk("R11 target kept", fallback_o, 32'h0000_1000);
        query("R11 depth cleared", 1'b0);
        do_begin(32'h0000_3000);
        chk("R11 new outer target", fallback_o, 32'h0000_3000);
        xabort_req = 1; xabort_imm = 8'hC3; conflict_i = 1; tick();
        chk("R4 explicit plus conflict, retry clear", status_o, 32'hC300_0005);
    endtask

    task automatic t_causes();
        do_begin(32'h10);
        xabort_imm = 8'hFF; conflict_i = 1; tick();
        chk("R5 conflict status", status_o, 32'h0000_0006);
        do_begin(32'h10);
        overflow_i = 1; breakpoint_i = 1; tick();
        chk("R6 overflow breakpoint status", status_o, 32'h0000_0018);
        do_begin(32'h10);
        abort_other_i = 1; tick();
        chk("R8 unrecognised abort status", status_o, 32'h0000_0000);
        chk("R8 abort strobe", {31'b0, abort_o}, 32'h1);
        do_begin(32'h10);
        do_begin(32'h20);
        abort_other_i = 1; tick();
        chk("R7 nested only", status_o, 32'h0000_0020);
    endtask

    task automatic t_depth_limit();
        for (int i = 0; i < MN; i++) do_begin(32'h100 + i);
        chk("R9 last legal begin", status_o, 32'hFFFF_FFFF);
        do_begin(32'h999);
        chk("R9 overflow abort", {31'b0, abort_o}, 32'h1);
        chk("R9 overflow status", status_o, 32'h0000_0028);
        chk("R9 target kept", fallback_o, 32'h100);
        query("R9 depth cleared", 1'b0);
    endtask

    task automatic t_illegal();
        do_end();
        chk("R10 end outside illegal", {31'b0, illegal_o}, 32'h1);
        chk("R10 end outside no commit", {31'b0, commit_o}, 32'h0);
        do_xab(8'h11);
        chk("R10 xabort outside illegal", {31'b0, illegal_o}, 32'h1);
        chk("R10 xabort outside no abort", {31'b0, abort_o}, 32'h0);
        conflict_i = 1; overflow_i = 1; abort_other_i = 1; tick();
        chk("R10 causes ignored", {31'b0, abort_o}, 32'h0);
        query("R10 depth unchanged", 1'b0);
        do_begin(32'h77);
        chk("R10 begin after illegal", fallback_o, 32'h77);
        do_end();
        chk("R10 depth was zero, commit", {31'b0, commit_o}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_nest_commit();
        t_explicit();
        t_causes();
        t_depth_limit();
        t_illegal();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule